// File: doc/BRIEF.md
# Host Request Parity Checker

This block protects the request phase of a split-transaction host bus, where each request takes two cycles. The address strobe marks the first cycle, which carries the address, the command and the strobe itself. The cycle after it carries byte enables and length on the same wires. In every cycle the block computes, as combinational outputs, two address parity bits, a request parity bit and a response parity bit, so that a bus master can drive them. It also compares the address and request parity bits received from the bus with the values it computes.

All parity is even: a parity bit is the XOR of the bits it covers. The upper address parity bit covers address bits 35..24. The lower one covers bits 23..3. The request parity bit covers the 5-bit request type together with the strobe. The response parity bit covers the 3-bit response code.

The check runs on both cycles of a request. A mismatch raises the address-error output for the one clock that follows the failing cycle, but only while checking is enabled. All values are in logical, active-high polarity. Any inversion for active-low bus wires belongs outside the block.

Top module: `hrp_checker`

## Requirements
- R1: `gen_addr_par[1]` equals the XOR of `req_addr[35:24]`, combinationally, in every cycle.
- R2: `gen_addr_par[0]` equals the XOR of `req_addr[23:3]`, combinationally, in every cycle.
- R3: `gen_req_par` equals the XOR of `req_type[4:0]` and `req_strobe`, combinationally, in every cycle.
- R4: `gen_rsp_par` equals the XOR of `rsp_code[2:0]`, combinationally, in every cycle.
- R5: In a cycle with `req_strobe` high and `chk_en` high, if `rx_addr_par` differs from the computed address parity in either bit, `addr_err` is high in the next cycle. When the check passes, `addr_err` is low in the next cycle.
- R6: In the cycle after a strobe cycle with `req_strobe` low (the second request cycle), the same address parity check applies, and a mismatch with `chk_en` high sets `addr_err` in the following cycle.
- R7: A mismatch between `rx_req_par` and the computed request parity, in either request cycle with `chk_en` high, sets `addr_err` in the next cycle.
- R8: With `chk_en` low in a cycle, `addr_err` is low in the next cycle, whatever parity is received.
- R9: A cycle that is neither a strobe cycle nor the cycle right after one is not checked. `addr_err` is low in the next cycle even if the received parity is wrong.
- R10: While `rst` is high, `addr_err` is low. The first cycle after `rst` falls is not treated as a second request cycle, even if a strobe came just before reset.
- R11: A strobe that arrives in a second request cycle starts a new request, so the cycle after it is checked as a second request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_addr | input | 33 | Request address, bits 35..3 |
| req_type | input | 5 | Request type / second-cycle request information |
| req_strobe | input | 1 | Address strobe, marks the first request cycle |
| rsp_code | input | 3 | Response code |
| rx_addr_par | input | 2 | Received address parity (bit 1 covers 35..24, bit 0 covers 23..3) |
| rx_req_par | input | 1 | Received request parity |
| chk_en | input | 1 | Enables reporting of parity errors |
| gen_addr_par | output | 2 | Computed address parity, same bit order as `rx_addr_par` |
| gen_req_par | output | 1 | Computed request parity |
| gen_rsp_par | output | 1 | Computed response parity |
| addr_err | output | 1 | Error pulse, one clock after a failing request cycle |

## Verification
A walking one over all 33 address bits shows that the split between the two address groups lies exactly between bits 23 and 24. A design with the boundary off by one would flip the wrong parity bit at bit 23 or bit 24.

A matrix of corruptions covers every combination of bad bits, each placed in the first cycle, the second cycle or an idle cycle, with checking both on and off. A design that checks only the strobe cycle would miss the second-cycle errors. One that checks every cycle would flag the idle-cycle errors. One that ignores the enable would pulse when checking is off.

Back-to-back strobes and a reset placed right after a strobe are also run. They catch phase tracking that fails to restart on a new strobe, or that treats the first cycle after reset as a second request cycle.

// File: rtl/hrp_pkg.sv
package hrp_pkg;

    localparam int ADDR_HI  = 35;
    localparam int ADDR_LO  = 3;
    localparam int AP_SPLIT = 24;
    localparam int REQ_W    = 5;
    localparam int RSP_W    = 3;
    localparam int AP_N     = 2;

    // where a request cycle sits within the request phase
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_FIRST  = 2'd1,
        PH_SECOND = 2'd2
    } phase_e;

    // parity bits that travel with a request cycle
    typedef struct packed {
        logic [AP_N-1:0] ap;
        logic            rp;
    } req_par_t;

    // lowest address bit covered by parity group g
    function automatic int grp_lo(input int g, input int lo, input int split);
        return (g == 0) ? lo : split;
    endfunction

    // highest address bit covered by parity group g
    function automatic int grp_hi(input int g, input int hi, input int split);
        return (g == 0) ? split - 1 : hi;
    endfunction

endpackage

// File: rtl/hrp_phase.sv
module hrp_phase (
    input  logic            clk,
    input  logic            rst,
    input  logic            strobe,
    output hrp_pkg::phase_e phase
);
    import hrp_pkg::*;

    logic second_q;

    always_ff @(posedge clk) begin
        if (rst) second_q <= 1'b0;
        else     second_q <= strobe;
    end

    always_comb begin
        if (strobe)        phase = PH_FIRST;
        else if (second_q) phase = PH_SECOND;
        else               phase = PH_IDLE;
    end

endmodule

// File: rtl/hrp_pargen.sv
module hrp_pargen #(
    parameter int ADDR_HI  = hrp_pkg::ADDR_HI,
    parameter int ADDR_LO  = hrp_pkg::ADDR_LO,
    parameter int AP_SPLIT = hrp_pkg::AP_SPLIT,
    parameter int REQ_W    = hrp_pkg::REQ_W,
    parameter int RSP_W    = hrp_pkg::RSP_W
) (
    input  logic [ADDR_HI:ADDR_LO] addr,
    input  logic [REQ_W-1:0]       req_type,
    input  logic                   strobe,
    input  logic [RSP_W-1:0]       rsp,
    output hrp_pkg::req_par_t      gen,
    output logic                   rsp_par
);
    import hrp_pkg::*;

    logic [AP_N-1:0] ap_bits;

    for (genvar g = 0; g < AP_N; g++) begin : g_grp
        localparam int LO = grp_lo(g, ADDR_LO, AP_SPLIT);
        localparam int HI = grp_hi(g, ADDR_HI, AP_SPLIT);
        assign ap_bits[g] = ^addr[HI:LO];
    end

    assign gen.ap  = ap_bits;
    assign gen.rp  = (^req_type) ^ strobe;
    assign rsp_par = ^rsp;

endmodule

// File: rtl/hrp_errchk.sv
module hrp_errchk (
    input  logic              clk,
    input  logic              rst,
    input  hrp_pkg::phase_e   phase,
    input  logic              chk_en,
    input  hrp_pkg::req_par_t gen,
    input  hrp_pkg::req_par_t rx,
    output logic              err
);
    import hrp_pkg::*;

    logic in_req;
    logic mism;
    logic err_q;

    assign in_req = (phase != PH_IDLE);
    assign mism   = (gen.ap != rx.ap) || (gen.rp != rx.rp);

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= chk_en && in_req && mism;
    end

    assign err = err_q;

endmodule

// File: rtl/hrp_checker.sv
module hrp_checker #(
    parameter int ADDR_HI  = hrp_pkg::ADDR_HI,
    parameter int ADDR_LO  = hrp_pkg::ADDR_LO,
    parameter int AP_SPLIT = hrp_pkg::AP_SPLIT,
    parameter int REQ_W    = hrp_pkg::REQ_W,
    parameter int RSP_W    = hrp_pkg::RSP_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_HI:ADDR_LO]   req_addr,
    input  logic [REQ_W-1:0]         req_type,
    input  logic                     req_strobe,
    input  logic [RSP_W-1:0]         rsp_code,
    input  logic [hrp_pkg::AP_N-1:0] rx_addr_par,
    input  logic                     rx_req_par,
    input  logic                     chk_en,
    output logic [hrp_pkg::AP_N-1:0] gen_addr_par,
    output logic                     gen_req_par,
    output logic                     gen_rsp_par,
    output logic                     addr_err
);
    import hrp_pkg::*;

    phase_e   phase;
    req_par_t gen;
    req_par_t rx;

    assign rx.ap = rx_addr_par;
    assign rx.rp = rx_req_par;

    hrp_phase u_phase (
        .clk    (clk),
        .rst    (rst),
        .strobe (req_strobe),
        .phase  (phase)
    );

    hrp_pargen #(
        .ADDR_HI  (ADDR_HI),
        .ADDR_LO  (ADDR_LO),
        .AP_SPLIT (AP_SPLIT),
        .REQ_W    (REQ_W),
        .RSP_W    (RSP_W)
    ) u_gen (
        .addr     (req_addr),
        .req_type (req_type),
        .strobe   (req_strobe),
        .rsp      (rsp_code),
        .gen      (gen),
        .rsp_par  (gen_rsp_par)
    );

    hrp_errchk u_chk (
        .clk    (clk),
        .rst    (rst),
        .phase  (phase),
        .chk_en (chk_en),
        .gen    (gen),
        .rx     (rx),
        .err    (addr_err)
    );

    assign gen_addr_par = gen.ap;
    assign gen_req_par  = gen.rp;

endmodule

// File: rtl/hrp_checker_sva.sv
module hrp_checker_sva #(
    parameter int ADDR_HI  = hrp_pkg::ADDR_HI,
    parameter int ADDR_LO  = hrp_pkg::ADDR_LO,
    parameter int AP_SPLIT = hrp_pkg::AP_SPLIT,
    parameter int REQ_W    = hrp_pkg::REQ_W,
    parameter int RSP_W    = hrp_pkg::RSP_W
) (
    input logic                     clk,
    input logic                     rst,
    input logic [ADDR_HI:ADDR_LO]   req_addr,
    input logic [REQ_W-1:0]         req_type,
    input logic                     req_strobe,
    input logic [RSP_W-1:0]         rsp_code,
    input logic [hrp_pkg::AP_N-1:0] rx_addr_par,
    input logic                     rx_req_par,
    input logic                     chk_en,
    input logic [hrp_pkg::AP_N-1:0] gen_addr_par,
    input logic                     gen_req_par,
    input logic                     gen_rsp_par,
    input logic                     addr_err
);
    logic       prev_s;
    logic [1:0] exp_ap;
    logic       exp_rp;

    always_ff @(posedge clk) begin
        if (rst) prev_s <= 1'b0;
        else     prev_s <= req_strobe;
    end

    assign exp_ap = {^req_addr[ADDR_HI:AP_SPLIT], ^req_addr[AP_SPLIT-1:ADDR_LO]};
    assign exp_rp = (^req_type) ^ req_strobe;

    p_ap_hi_r1: assert property (@(posedge clk) disable iff (rst)
        gen_addr_par[1] == exp_ap[1]);
    p_ap_lo_r2: assert property (@(posedge clk) disable iff (rst)
        gen_addr_par[0] == exp_ap[0]);
    p_rp_gen_r3: assert property (@(posedge clk) disable iff (rst)
        gen_req_par == exp_rp);
    p_rsp_gen_r4: assert property (@(posedge clk) disable iff (rst)
        gen_rsp_par == (^rsp_code));
    p_first_err_r5: assert property (@(posedge clk) disable iff (rst)
        (chk_en && req_strobe && (rx_addr_par != exp_ap)) |=> addr_err);
    p_second_err_r6: assert property (@(posedge clk) disable iff (rst)
        (chk_en && prev_s && !req_strobe && (rx_addr_par != exp_ap)) |=> addr_err);
    p_rp_err_r7: assert property (@(posedge clk) disable iff (rst)
        (chk_en && (req_strobe || prev_s) && (rx_req_par != exp_rp)) |=> addr_err);
    p_off_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !chk_en |=> !addr_err);
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (!req_strobe && !prev_s) |=> !addr_err);
    p_reset_quiet_r10: assert property (@(posedge clk)
        $past(rst) |-> !addr_err);

endmodule

bind hrp_checker hrp_checker_sva #(
    .ADDR_HI  (ADDR_HI),
    .ADDR_LO  (ADDR_LO),
    .AP_SPLIT (AP_SPLIT),
    .REQ_W    (REQ_W),
    .RSP_W    (RSP_W)
) u_sva (
    .clk          (clk),
    .rst          (rst),
    .req_addr     (req_addr),
    .req_type     (req_type),
    .req_strobe   (req_strobe),
    .rsp_code     (rsp_code),
    .rx_addr_par  (rx_addr_par),
    .rx_req_par   (rx_req_par),
    .chk_en       (chk_en),
    .gen_addr_par (gen_addr_par),
    .gen_req_par  (gen_req_par),
    .gen_rsp_par  (gen_rsp_par),
    .addr_err     (addr_err)
);

// File: tb/tb_hrp_checker.sv
module tb_hrp_checker;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [35:3] req_addr = '0;
    logic [4:0]  req_type = '0;
    logic        req_strobe = 1'b0;
    logic [2:0]  rsp_code = '0;
    logic [1:0]  rx_addr_par = '0;
    logic        rx_req_par = 1'b0;
    logic        chk_en = 1'b0;
    logic [1:0]  gen_addr_par;
    logic        gen_req_par;
    logic        gen_rsp_par;
    logic        addr_err;

    int          n_chk = 0;
    int          n_fail = 0;
    logic        done = 1'b0;
    logic        prev_s = 1'b0;
    logic [31:0] lfsr = 32'hACE1_1234;

    always #2.5 clk = ~clk;

    hrp_checker dut (
        .clk          (clk),
        .rst          (rst),
        .req_addr     (req_addr),
        .req_type     (req_type),
        .req_strobe   (req_strobe),
        .rsp_code     (rsp_code),
        .rx_addr_par  (rx_addr_par),
        .rx_req_par   (rx_req_par),
        .chk_en       (chk_en),
        .gen_addr_par (gen_addr_par),
        .gen_req_par  (gen_req_par),
        .gen_rsp_par  (gen_rsp_par),
        .addr_err     (addr_err)
    );

    function automatic logic [1:0] model_ap(input logic [35:3] a);
        int hi = 0;
        int lo = 0;
        for (int i = 3; i <= 35; i++) begin
            if (a[i]) begin
                if (i >= 24) hi++;
                else         lo++;
            end
        end
        return {1'(hi % 2), 1'(lo % 2)};
    endfunction

    function automatic logic model_odd(input logic [7:0] v);
        int c = 0;
        for (int i = 0; i < 8; i++) if (v[i]) c++;
        return 1'(c % 2);
    endfunction

    task automatic check_bit(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic next_rand();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    endtask

    // one bus cycle: drive at negedge, check generated parity, then the pulse after the edge
    task automatic step(input logic [35:3] a, input logic [4:0] t, input logic s,
                        input logic [2:0] r, input logic [1:0] apc, input logic rpc,
                        input logic en, input string tag);
        logic [1:0] eap;
        logic       erp;
        logic       eerr;
        @(negedge clk);
        eap = model_ap(a);
        erp = model_odd({2'b00, s, t});
        req_addr    = a;
        req_type    = t;
        req_strobe  = s;
        rsp_code    = r;
        rx_addr_par = eap ^ apc;
        rx_req_par  = erp ^ rpc;
        chk_en      = en;
        #1;
        check_bit("R1", gen_addr_par[1], eap[1]);
        check_bit("R2", gen_addr_par[0], eap[0]);
        check_bit("R3", gen_req_par, erp);
        check_bit("R4", gen_rsp_par, model_odd({5'b0, r}));
        eerr = en && (s || prev_s) && ((apc != 2'b00) || rpc);
        prev_s = s;
        @(posedge clk);
        #1;
        check_bit(tag, addr_err, eerr);
    endtask

    function automatic string pick_tag(input logic en, input int pos, input logic [2:0] c);
        if (!en)      return "R8";
        if (pos == 2) return "R9";
        if (c != 3'b000 && c[1:0] == 2'b00) return "R7";
        return (pos == 0) ? "R5" : "R6";
    endfunction

    initial begin
        #(5.0 * 190000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R10: pulse held low during reset
        repeat (3) @(posedge clk);
        #1;
        check_bit("R10", addr_err, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        // R1, R2: walking one across the address, split between bits 23 and 24
        for (int i = 0; i < 33; i++) begin
            logic [35:3] a;
            a = '0;
            a[3 + i] = 1'b1;
            step(a, 5'd0, 1'b0, 3'(i), 2'b00, 1'b0, 1'b0, "R8");
        end

        // R3, R4: every request type with and without strobe, checking off
        for (int i = 0; i < 64; i++) begin
            next_rand();
            step({lfsr[0], lfsr}, i[4:0], i[5], i[2:0], 2'b11, 1'b1, 1'b0, "R8");
        end

        // R5-R9: every corruption in first, second or idle cycle, enable on and off
        for (int en = 0; en < 2; en++) begin
            for (int pos = 0; pos < 3; pos++) begin
                for (int c = 0; c < 8; c++) begin
                    for (int ph = 0; ph < 3; ph++) begin
                        logic [2:0] cc;
                        cc = (ph == pos) ? 3'(c) : 3'b000;
                        next_rand();
                        step({lfsr[7], lfsr}, lfsr[12:8], (ph == 0), lfsr[2:0],
                             cc[1:0], cc[2], 1'(en), pick_tag(1'(en), ph, cc));
                    end
                end
            end
        end

        // R11: strobe in the second cycle restarts, following cycle checked as second
        step(33'h1_2345_6789, 5'h0A, 1'b1, 3'd1, 2'b00, 1'b0, 1'b1, "R11");
        step(33'h0_0F0F_0F0F, 5'h13, 1'b1, 3'd2, 2'b00, 1'b0, 1'b1, "R11");
        step(33'h1_FFFF_0000, 5'h05, 1'b0, 3'd3, 2'b01, 1'b0, 1'b1, "R11");
        step(33'h1_FFFF_0000, 5'h05, 1'b0, 3'd3, 2'b01, 1'b0, 1'b1, "R11");

        // R10: a strobe right before reset does not make the first cycle after it a second cycle
        step(33'h0_1111_2222, 5'h1F, 1'b1, 3'd0, 2'b00, 1'b0, 1'b1, "R10");
        @(negedge clk);
        rst = 1'b1;
        req_strobe = 1'b0;
        prev_s = 1'b0;
        @(posedge clk);
        #1;
        check_bit("R10", addr_err, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        step(33'h0_1111_2222, 5'h1F, 1'b0, 3'd0, 2'b10, 1'b1, 1'b1, "R10");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule